// File: doc/BRIEF.md
# Accelerator call/return register agent

This block is the register slave that sits between a host processor and a hardware function (the kernel). The host writes the kernel's input arguments into read/write registers whose contents drive the kernel's input ports continuously. It then writes a start word, and the agent sends a one-cycle launch pulse to the kernel. The agent keeps its own busy flag for the call. When the kernel signals completion, the agent captures the kernel's 192-bit result into read-only words, sets a sticky done flag and raises an interrupt status bit. The status bit drives a level interrupt through a host-controlled enable.

The bus is 64 bits wide with byte addresses. Every register is 8-byte aligned, so address bits [2:0] are ignored. A write takes effect in the cycle it is presented. A read returns its data exactly one cycle after the request, together with a valid strobe. The word offsets are fixed because host software decodes them. The layout is:

- 0x00: status. Bit 0 is busy.
- 0x08: start. This word is write-only.
- 0x10: interrupt enable.
- 0x18: call state. Bit 0 is the interrupt status and bit 1 is done.
- 0x20 to 0x30: result words.
- 0x38 onward: arguments.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset the following all read as 0: busy (0x00 bit 0), done (0x18 bit 1), interrupt status (0x18 bit 0), interrupt enable (0x10 bit 0) and every argument register. The `kick`, `irq` and `host_rvalid` outputs are also low.
- R2: A write to 0x08 with `host_be[0]`=1 and data bit 0 = 1, made while busy is 0, is accepted. `kick` is then high for exactly the one following cycle, and busy reads 1 from that cycle on.
- R3: A start write made while busy is 1 produces no `kick` and does not change any state.
- R4: A `fin` pulse while busy is 1 has these effects on the next cycle: busy clears, done sets and interrupt status sets. Done then stays 1 until the next accepted start, which clears it.
- R5: A `fin` pulse while busy is 0 is ignored. The result words, done and interrupt status keep their values.
- R6: On an accepted completion, `ret_data` is captured. It reads back as three 64-bit words: bits [63:0] at 0x20, [127:64] at 0x28 and [191:128] at 0x30.
- R7: Interrupt enable (0x10 bit 0) is read/write. `irq` equals interrupt status AND interrupt enable.
- R8: Writing 1 to 0x18 bit 0 clears interrupt status, and writing 0 has no effect. If a completion is accepted in the same cycle as the clear, the status stays set.
- R9: The argument registers are read/write, and each drives its output port. `parm_s` (32 bits) is at 0x38. `parm_w` (192 bits) is at 0x40, 0x48 and 0x50, least significant word first. `parm_l` (64 bits) is at 0x58 and `parm_b` (8 bits) is at 0x60. Bus byte lane k (data bits 8k+7:8k) updates a byte only when `host_be[k]` is 1.
- R10: Writes to the following are ignored: reserved bits (lanes 4 to 7 at 0x38, lanes 1 to 7 at 0x60), read-only words (0x00 and 0x20 to 0x30), done (0x18 bit 1) and unmapped words. Reserved bits read back as don't-care.
- R11: A read request at cycle t raises `host_rvalid` at cycle t+1 only, with the data sampled at cycle t. Without a request, `host_rvalid` is 0.
- R12: Writes to start, interrupt enable and the status clear take effect only when `host_be[0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W (8) | Byte address; bits [2:0] ignored |
| host_wr | input | 1 | Write request |
| host_wdata | input | 64 | Write data |
| host_be | input | 8 | Byte enables for writes |
| host_rd | input | 1 | Read request |
| host_rdata | output | 64 | Read data, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| kick | output | 1 | One-cycle launch pulse to the kernel |
| fin | input | 1 | Kernel completion strobe |
| ret_data | input | RET_W (192) | Kernel result, sampled on accepted `fin` |
| parm_s | output | PS_W (32) | Argument register at 0x38 |
| parm_w | output | PW_W (192) | Argument register at 0x40..0x50 |
| parm_l | output | PL_W (64) | Argument register at 0x58 |
| parm_b | output | PB_W (8) | Argument register at 0x60 |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets three hazards:

- A start issued during a running call. A design that let it through would pulse `kick` twice and restart the kernel mid-run.
- A clear landing in the same cycle as a completion. A design that let the clear win would drop an interrupt for good.
- A stray `fin` while idle. A design that did not qualify `fin` with busy would overwrite the captured result.

Partial byte-enable writes, and writes to the upper lanes of narrow arguments, expose a design that ignores lane enables or stores reserved bits. A read of done after a new start catches a design that keeps done sticky across calls.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;
  localparam int BUS_W = 64;
  localparam int LANES = BUS_W / 8;
  // Fixed word slots of the call/return area (byte offset = slot * 8)
  localparam int SLOT_BUSY = 0;
  localparam int SLOT_GO   = 1;
  localparam int SLOT_IEN  = 2;
  localparam int SLOT_ISR  = 3;
  localparam int SLOT_RET  = 4;

  function automatic int words_for(input int bits);
    return (bits + BUS_W - 1) / BUS_W;
  endfunction

  function automatic logic irq_level(input logic st, input logic en);
    return st & en;
  endfunction

  // A completion in the same cycle as a clear keeps the status set
  function automatic logic isr_next(input logic cur, input logic cmp, input logic clr);
    return cmp | (cur & ~clr);
  endfunction
endpackage

// File: rtl/acr_arg_bank.sv
module acr_arg_bank
  import accel_ctl_pkg::*;
#(
  parameter int W     = 32,
  parameter int BASE  = 7,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [BUS_W-1:0] wdata,
  input  logic [LANES-1:0] be,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     q,
  output logic             rd_hit,
  output logic [BUS_W-1:0] rd_word
);
  localparam int NB = W / 8;
  localparam int NW = words_for(W);

  logic [NW*BUS_W-1:0] pad;
  logic unused_in;
  assign unused_in = ^{wdata, be};

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_byte
      localparam int WD = b / LANES;
      localparam int LN = b % LANES;
      logic [7:0] r;
      logic       wen;
      assign wen = wr && (wr_idx == IDX_W'(BASE + WD)) && be[LN];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r <= '0;
        else if (wen) r <= wdata[8*LN +: 8];
      end
      assign q[8*b +: 8] = r;
    end
  endgenerate

  always_comb begin
    pad         = '0;
    pad[W-1:0]  = q;
    rd_hit      = 1'b0;
    rd_word     = '0;
    for (int k = 0; k < NW; k++) begin
      if (rd_idx == IDX_W'(BASE + k)) begin
        rd_hit  = 1'b1;
        rd_word = pad[BUS_W*k +: BUS_W];
      end
    end
  end
endmodule

// File: rtl/acr_call_ctrl.sv
module acr_call_ctrl
  import accel_ctl_pkg::*;
#(
  parameter int RET_W = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic             clr_req,
  input  logic             ien_we,
  input  logic             ien_d,
  input  logic             fin,
  input  logic [RET_W-1:0] ret_in,
  output logic             accept,
  output logic             complete,
  output logic             busy,
  output logic             done,
  output logic             isr,
  output logic             ien,
  output logic             kick,
  output logic [RET_W-1:0] ret_q
);
  assign accept   = go_req & ~busy;
  assign complete = fin & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      isr   <= 1'b0;
      ien   <= 1'b0;
      kick  <= 1'b0;
      ret_q <= '0;
    end else begin
      kick <= accept;
      if (accept) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (complete) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      isr <= isr_next(isr, complete, clr_req);
      if (ien_we)   ien   <= ien_d;
      if (complete) ret_q <= ret_in;
    end
  end
endmodule

// File: rtl/acr_read_port.sv
module acr_read_port
  import accel_ctl_pkg::*;
#(
  parameter int RET_W = 192,
  parameter int IDX_W = 5,
  parameter int NBANK = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic                        busy,
  input  logic                        done,
  input  logic                        isr,
  input  logic                        ien,
  input  logic [RET_W-1:0]            ret_q,
  input  logic [NBANK-1:0]            bank_hit,
  input  logic [NBANK-1:0][BUS_W-1:0] bank_word,
  output logic [BUS_W-1:0]            rdata,
  output logic                        rvalid
);
  localparam int RNW = words_for(RET_W);

  logic [RNW*BUS_W-1:0] rpad;
  logic [BUS_W-1:0]     nxt;

  always_comb begin
    rpad            = '0;
    rpad[RET_W-1:0] = ret_q;
    nxt             = '0;
    if (rd_idx == IDX_W'(SLOT_BUSY)) nxt[0]   = busy;
    if (rd_idx == IDX_W'(SLOT_IEN))  nxt[0]   = ien;
    if (rd_idx == IDX_W'(SLOT_ISR))  nxt[1:0] = {done, isr};
    for (int k = 0; k < RNW; k++)
      if (rd_idx == IDX_W'(SLOT_RET + k)) nxt = rpad[BUS_W*k +: BUS_W];
    for (int j = 0; j < NBANK; j++)
      if (bank_hit[j]) nxt = bank_word[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= nxt;
    end
  end
endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
  import accel_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RET_W  = 192,
  parameter int PS_W   = 32,
  parameter int PW_W   = 192,
  parameter int PL_W   = 64,
  parameter int PB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [BUS_W-1:0]  host_wdata,
  input  logic [LANES-1:0]  host_be,
  input  logic              host_rd,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              host_rvalid,
  output logic              kick,
  input  logic              fin,
  input  logic [RET_W-1:0]  ret_data,
  output logic [PS_W-1:0]   parm_s,
  output logic [PW_W-1:0]   parm_w,
  output logic [PL_W-1:0]   parm_l,
  output logic [PB_W-1:0]   parm_b,
  output logic              irq
);
  localparam int IDX_W   = ADDR_W - 3;
  localparam int PS_SLOT = SLOT_RET + words_for(RET_W);
  localparam int PW_SLOT = PS_SLOT + words_for(PS_W);
  localparam int PL_SLOT = PW_SLOT + words_for(PW_W);
  localparam int PB_SLOT = PL_SLOT + words_for(PL_W);

  logic [IDX_W-1:0] idx;
  logic unused_lo;
  logic go_req, clr_req, ien_we;
  logic accept, complete, busy, done, isr, ien;
  logic [RET_W-1:0] ret_q;
  logic [3:0]            bank_hit;
  logic [3:0][BUS_W-1:0] bank_word;

  assign idx       = host_addr[ADDR_W-1:3];
  assign unused_lo = ^host_addr[2:0];

  assign go_req  = host_wr && (idx == IDX_W'(SLOT_GO))  && host_be[0] && host_wdata[0];
  assign clr_req = host_wr && (idx == IDX_W'(SLOT_ISR)) && host_be[0] && host_wdata[0];
  assign ien_we  = host_wr && (idx == IDX_W'(SLOT_IEN)) && host_be[0];

  acr_call_ctrl #(.RET_W(RET_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .clr_req(clr_req),
    .ien_we(ien_we), .ien_d(host_wdata[0]), .fin(fin), .ret_in(ret_data),
    .accept(accept), .complete(complete), .busy(busy), .done(done),
    .isr(isr), .ien(ien), .kick(kick), .ret_q(ret_q)
  );

  acr_arg_bank #(.W(PS_W), .BASE(PS_SLOT), .IDX_W(IDX_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wr_idx(idx), .wdata(host_wdata),
    .be(host_be), .rd_idx(idx), .q(parm_s), .rd_hit(bank_hit[0]), .rd_word(bank_word[0])
  );
  acr_arg_bank #(.W(PW_W), .BASE(PW_SLOT), .IDX_W(IDX_W)) u_pw (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wr_idx(idx), .wdata(host_wdata),
    .be(host_be), .rd_idx(idx), .q(parm_w), .rd_hit(bank_hit[1]), .rd_word(bank_word[1])
  );
  acr_arg_bank #(.W(PL_W), .BASE(PL_SLOT), .IDX_W(IDX_W)) u_pl (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wr_idx(idx), .wdata(host_wdata),
    .be(host_be), .rd_idx(idx), .q(parm_l), .rd_hit(bank_hit[2]), .rd_word(bank_word[2])
  );
  acr_arg_bank #(.W(PB_W), .BASE(PB_SLOT), .IDX_W(IDX_W)) u_pb (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wr_idx(idx), .wdata(host_wdata),
    .be(host_be), .rd_idx(idx), .q(parm_b), .rd_hit(bank_hit[3]), .rd_word(bank_word[3])
  );

  acr_read_port #(.RET_W(RET_W), .IDX_W(IDX_W), .NBANK(4)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .rd_idx(idx), .busy(busy),
    .done(done), .isr(isr), .ien(ien), .ret_q(ret_q), .bank_hit(bank_hit),
    .bank_word(bank_word), .rdata(host_rdata), .rvalid(host_rvalid)
  );

  assign irq = irq_level(isr, ien);
endmodule

// File: rtl/acr_chk.sv
module acr_chk (
  input logic clk,
  input logic rst_n,
  input logic kick,
  input logic irq,
  input logic busy,
  input logic done,
  input logic isr,
  input logic ien,
  input logic accept,
  input logic complete,
  input logic host_rd,
  input logic host_rvalid
);
  // R2
  kick_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> busy);
  // R3
  kick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  // R4
  complete_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (!busy && done && isr));
  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |=> done);
  // R8
  isr_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr |-> (done || busy));
  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(complete) || $rose(ien)));
  // R11
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
  // R11
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);
endmodule

bind accel_ctl_regs acr_chk u_acr_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .irq(irq), .busy(busy), .done(done),
  .isr(isr), .ien(ien), .accept(accept), .complete(complete),
  .host_rd(host_rd), .host_rvalid(host_rvalid)
);

// File: tb/test_accel_ctl_regs.sv
`timescale 1ns/1ps
module test_accel_ctl_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   host_addr = '0;
  logic         host_wr = 1'b0;
  logic [63:0]  host_wdata = '0;
  logic [7:0]   host_be = '0;
  logic         host_rd = 1'b0;
  logic [63:0]  host_rdata;
  logic         host_rvalid;
  logic         kick;
  logic         fin;
  logic [191:0] ret_data;
  logic [31:0]  parm_s;
  logic [191:0] parm_w;
  logic [63:0]  parm_l;
  logic [7:0]   parm_b;
  logic         irq;

  int checks = 0;
  int errors = 0;
  int kicks  = 0;

  // kernel stub and stray-completion driver
  logic         stub_en = 1'b1;
  logic         stub_fin = 1'b0;
  logic [191:0] stub_ret = '0;
  logic [191:0] last_ret = '0;
  logic         sp_fin = 1'b0;
  logic [191:0] sp_ret = '0;
  int           cnt = 0;
  int           runs = 0;

  assign fin      = stub_fin | sp_fin;
  assign ret_data = sp_fin ? sp_ret : stub_ret;

  always #2.5 clk = ~clk;

  accel_ctl_regs i_accel_ctl_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_be(host_be), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .kick(kick), .fin(fin),
    .ret_data(ret_data), .parm_s(parm_s), .parm_w(parm_w), .parm_l(parm_l),
    .parm_b(parm_b), .irq(irq)
  );

  always @(negedge clk) begin
    if (stub_fin) stub_fin = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        runs++;
        stub_ret = {64'hA000_0000_0000_0000 + 64'(runs),
                    64'hB0B0_0000_0000_0000 ^ 64'(runs * 7),
                    64'hC3C3_C3C3_0000_0000 | 64'(runs)};
        last_ret = stub_ret;
        stub_fin = 1'b1;
      end
    end
    if (kick) kicks++;
    if (kick && stub_en && cnt == 0) cnt = 12;
  end

  // ---------------- behavioural reference model ----------------
  logic [63:0] shadow [0:15];
  logic m_busy, m_done, m_isr, m_ien;
  logic e_kick, e_rv;
  logic [63:0] e_rdata, e_rmask;

  function automatic logic [63:0] wmask(input int ix);
    if (ix == 7)              return 64'h0000_0000_FFFF_FFFF;
    if (ix >= 8 && ix <= 11)  return '1;
    if (ix == 12)             return 64'hFF;
    return '0;
  endfunction

  function automatic logic [63:0] rmask(input int ix);
    if (ix == 0 || ix == 2)  return 64'h1;
    if (ix == 3)             return 64'h3;
    if (ix >= 4 && ix <= 6)  return '1;
    return wmask(ix);
  endfunction

  function automatic logic [63:0] lanes(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int k = 0; k < 8; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  always @(posedge clk) begin : model
    int ix;
    logic acc, cmp;
    logic [63:0] m;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) shadow[i] = '0;
      m_busy = 0; m_done = 0; m_isr = 0; m_ien = 0;
      e_kick = 0; e_rv = 0; e_rdata = '0; e_rmask = '0;
    end else begin
      ix = int'(host_addr[7:3]);
      e_rv = host_rd;
      if (host_rd) begin
        e_rmask = rmask(ix);
        case (ix)
          0:       e_rdata = {63'd0, m_busy};
          2:       e_rdata = {63'd0, m_ien};
          3:       e_rdata = {62'd0, m_done, m_isr};
          default: e_rdata = (ix >= 4 && ix <= 12) ? shadow[ix] : 64'd0;
        endcase
      end
      acc = host_wr && ix == 1 && host_be[0] && host_wdata[0] && !m_busy;
      cmp = fin && m_busy;
      e_kick = acc;
      if (host_wr) begin
        m = lanes(host_be) & wmask(ix);
        if (ix >= 7 && ix <= 12) shadow[ix] = (shadow[ix] & ~m) | (host_wdata & m);
        if (ix == 2 && host_be[0]) m_ien = host_wdata[0];
        if (ix == 3 && host_be[0] && host_wdata[0]) m_isr = 1'b0;
      end
      if (cmp) begin
        m_isr = 1; m_done = 1; m_busy = 0;
        shadow[4] = ret_data[63:0];
        shadow[5] = ret_data[127:64];
        shadow[6] = ret_data[191:128];
      end
      if (acc) begin m_busy = 1; m_done = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(kick === e_kick, "R2 kick pulse", 192'(kick), 192'(e_kick));
      chk(irq === (m_isr & m_ien), "R7 irq level", 192'(irq), 192'(m_isr & m_ien));
      chk(parm_s === shadow[7][31:0], "R9 parm_s", 192'(parm_s), 192'(shadow[7][31:0]));
      chk(parm_w === {shadow[10], shadow[9], shadow[8]}, "R9 parm_w", parm_w,
          {shadow[10], shadow[9], shadow[8]});
      chk(parm_l === shadow[11], "R9 parm_l", 192'(parm_l), 192'(shadow[11]));
      chk(parm_b === shadow[12][7:0], "R9 parm_b", 192'(parm_b), 192'(shadow[12][7:0]));
      chk(host_rvalid === e_rv, "R11 rvalid", 192'(host_rvalid), 192'(e_rv));
      if (e_rv)
        chk((host_rdata & e_rmask) === (e_rdata & e_rmask), "R11 read data",
            192'(host_rdata & e_rmask), 192'(e_rdata & e_rmask));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int ix, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    host_addr = 8'(ix * 8); host_wr = 1'b1; host_wdata = d; host_be = be;
    @(negedge clk);
    host_wr = 1'b0; host_be = '0;
  endtask

  task automatic rd(input int ix, output logic [63:0] d);
    @(negedge clk);
    host_addr = 8'(ix * 8); host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; d = host_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [63:0] d;
    int k0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(parm_s == 0 && parm_w == 0 && parm_l == 0 && parm_b == 0, "R1 args zero",
        192'(parm_l), 192'd0);
    chk(!irq && !kick && !host_rvalid, "R1 outputs low", 192'({irq, kick, host_rvalid}), 192'd0);
    rd(0, d); chk(d[0] == 1'b0, "R1 busy", 192'(d[0]), 192'd0);
    rd(3, d); chk(d[1:0] == 2'b00, "R1 done/status", 192'(d[1:0]), 192'd0);
    rd(2, d); chk(d[0] == 1'b0, "R1 enable", 192'(d[0]), 192'd0);

    // R9 arguments with byte enables
    wr(7, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF);
    chk(parm_s == 32'hCAFE_F00D, "R9 parm_s write", 192'(parm_s), 192'h0CAFEF00D);
    wr(11, 64'h1122_3344_5566_7788, 8'hFF);
    wr(11, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
    chk(parm_l == 64'h1122_3344_AAAA_AAAA, "R9 partial lanes", 192'(parm_l),
        192'h1122_3344_AAAA_AAAA);
    wr(8, 64'h0101_0101_0101_0101, 8'hFF);
    wr(9, 64'h0202_0202_0202_0202, 8'hFF);
    wr(10, 64'h0303_0303_0303_0303, 8'hFF);
    rd(9, d); chk(d == 64'h0202_0202_0202_0202, "R9 parm_w middle word", 192'(d),
        192'h0202_0202_0202_0202);
    wr(12, 64'hFFFF_FFFF_FFFF_FF5A, 8'h01);
    chk(parm_b == 8'h5A, "R9 parm_b", 192'(parm_b), 192'h5A);

    // R10 ignored writes
    wr(7, 64'hFFFF_FFFF_0000_0000, 8'hF0);
    chk(parm_s == 32'hCAFE_F00D, "R10 reserved lanes", 192'(parm_s), 192'h0CAFEF00D);
    wr(3, 64'h2, 8'hFF);
    rd(3, d); chk(d[1] == 1'b0, "R10 done read-only", 192'(d[1]), 192'd0);
    wr(5, '1, 8'hFF);
    rd(5, d); chk(d == 64'd0, "R10 result read-only", 192'(d), 192'd0);
    k0 = kicks;
    wr(0, 64'h1, 8'hFF);
    rd(0, d); chk(d[0] == 1'b0 && kicks == k0, "R10 status write ignored", 192'(d[0]), 192'd0);

    // R2 / R3 launch and launch-while-busy
    wr(2, 64'h1, 8'hFF);
    rd(2, d); chk(d[0] == 1'b1, "R7 enable readback", 192'(d[0]), 192'd1);
    k0 = kicks;
    wr(1, 64'h1, 8'h01);
    rd(0, d); chk(d[0] == 1'b1, "R2 busy after start", 192'(d[0]), 192'd1);
    chk(kicks == k0 + 1, "R2 one kick", 192'(kicks), 192'(k0 + 1));
    wr(1, 64'h1, 8'hFF);
    repeat (2) @(negedge clk);
    chk(kicks == k0 + 1, "R3 start while busy", 192'(kicks), 192'(k0 + 1));
    repeat (20) @(negedge clk);

    // R4 / R6 / R7 completion
    rd(3, d); chk(d[1:0] == 2'b11, "R4 done and status", 192'(d[1:0]), 192'd3);
    rd(0, d); chk(d[0] == 1'b0, "R4 busy cleared", 192'(d[0]), 192'd0);
    chk(irq == 1'b1, "R7 irq raised", 192'(irq), 192'd1);
    rd(4, d); chk(d == last_ret[63:0], "R6 word 0", 192'(d), 192'(last_ret[63:0]));
    rd(5, d); chk(d == last_ret[127:64], "R6 word 1", 192'(d), 192'(last_ret[127:64]));
    rd(6, d); chk(d == last_ret[191:128], "R6 word 2", 192'(d), 192'(last_ret[191:128]));

    // R8 / R12 clear behaviour
    wr(3, 64'h0, 8'hFF);
    rd(3, d); chk(d[0] == 1'b1, "R8 write 0 keeps status", 192'(d[0]), 192'd1);
    wr(3, 64'h1, 8'h00);
    rd(3, d); chk(d[0] == 1'b1, "R12 clear needs lane 0", 192'(d[0]), 192'd1);
    wr(3, 64'h1, 8'h01);
    rd(3, d); chk(d[1:0] == 2'b10, "R8 cleared, R4 done kept", 192'(d[1:0]), 192'd2);
    chk(irq == 1'b0, "R8 irq dropped", 192'(irq), 192'd0);

    // R12 start without lane 0
    k0 = kicks;
    wr(1, 64'h1, 8'hFE);
    repeat (3) @(negedge clk);
    chk(kicks == k0, "R12 start needs lane 0", 192'(kicks), 192'(k0));
    wr(2, 64'h0, 8'h00);
    rd(2, d); chk(d[0] == 1'b1, "R12 enable needs lane 0", 192'(d[0]), 192'd1);

    // R5 stray completion while idle
    @(negedge clk); sp_ret = {3{64'h5555_6666_7777_8888}}; sp_fin = 1'b1;
    @(negedge clk); sp_fin = 1'b0;
    rd(4, d); chk(d == last_ret[63:0], "R5 result kept", 192'(d), 192'(last_ret[63:0]));
    rd(3, d); chk(d[1:0] == 2'b10, "R5 status kept", 192'(d[1:0]), 192'd2);

    // R8 completion and clear in the same cycle
    stub_en = 1'b0;
    wr(1, 64'h1, 8'h01);
    rd(3, d); chk(d[1] == 1'b0, "R4 done cleared by start", 192'(d[1]), 192'd0);
    @(negedge clk);
    host_addr = 8'(3 * 8); host_wr = 1'b1; host_wdata = 64'h1; host_be = 8'h01;
    sp_ret = {64'h3, 64'h2, 64'h1}; sp_fin = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_be = '0; sp_fin = 1'b0;
    stub_en = 1'b1;
    rd(3, d); chk(d[1:0] == 2'b11, "R8 completion beats clear", 192'(d[1:0]), 192'd3);
    rd(5, d); chk(d == 64'h2, "R6 captured word 1", 192'(d), 192'h2);

    // R7 masking
    wr(2, 64'h0, 8'hFF);
    chk(irq == 1'b0, "R7 masked", 192'(irq), 192'd0);
    wr(2, 64'h1, 8'h01);
    chk(irq == 1'b1, "R7 unmasked", 192'(irq), 192'd1);

    // second full call through the stub
    wr(3, 64'h1, 8'h01);
    wr(1, 64'h1, 8'h01);
    repeat (20) @(negedge clk);
    rd(6, d); chk(d == last_ret[191:128], "R6 second call", 192'(d), 192'(last_ret[191:128]));

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule